// File: doc/BRIEF.md
# Bus-Width Matching Packer with Lane Reordering

This block sits at the edge of a port whose external bus can run at full width (36 bits), half width (18 bits) or quarter width (9 bits). It collects one, two or four narrow transfers into one 36-bit long word. It can reorder the four 9-bit lanes of that word, and then hands the result downstream. A 2-bit size code and an order bit are registered on one clock edge and take effect on the next one. A size change asked for in the middle of a long word waits until that word is complete. A fourth size code marks a full-width transfer aimed at the mailbox path, and a side flag travels with that word.

Both data sides use valid/ready. A transfer is taken on a rising edge when `in_valid` and `in_ready` are both high. The block holds one finished word. `in_ready` is high when that slot is empty or is being emptied in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the word, its mailbox flag and `out_valid` stay unchanged, and no input is taken. The lane-reorder mode is sampled with the first transfer of each long word and is used for the whole word.

Top module: `bm_bus_matcher`

## Requirements
- R1: After reset `out_valid` and `out_mbox` are low, `in_ready` is high, the active size is long word and the active order is lower part first.
- R2: Size codes: 0 = long word, 1 = word, 2 = byte, 3 = mailbox. `size_sel` and `order_sel` are registered on a rising edge and become active on the following edge. A transfer taken on that second edge still uses the old size.
- R3: In long-word size, each accepted transfer produces one output word built from `in_data[35:0]`.
- R4: In word size, two transfers make one long word, each carrying its part in `in_data[17:0]`. With order 0 the first goes to bits [17:0] and the second to [35:18].
- R5: In byte size, four transfers make one long word, each carrying its part in `in_data[8:0]`. With order 0 transfer k fills bits [9k+8:9k].
- R6: With order 1, the parts fill the word from the high end: transfer k goes to slot n-1-k, where n is the number of parts per long word.
- R7: Size code 3 takes one full 36-bit transfer, and the resulting word leaves with `out_mbox` high. Every other size leaves with `out_mbox` low. `out_mbox` is never high without `out_valid`.
- R8: With lanes L0=[8:0] … L3=[35:27], the output lane i is taken from assembled lane s(i). Mode 0 gives s(i)=i (no change). Mode 1 gives s(i)=3-i (full lane reversal). Mode 2 gives s(i)=i xor 2 (halves exchanged). Mode 3 gives s(i)=i xor 1 (lanes exchanged within each half).
- R9: `swap_sel` is sampled with the first transfer of a long word. Its value on later transfers of the same word has no effect.
- R10: A size or order change requested while a long word is partly collected becomes active only after that word completes.
- R11: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_data` and `out_mbox` hold their values.
- R12: In word and byte size, the bits of `in_data` above the part width have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| size_sel | input | 2 | Requested bus size code |
| order_sel | input | 1 | Requested part order (1 = high part first) |
| swap_sel | input | 2 | Lane reorder mode, sampled per long word |
| in_valid | input | 1 | Input transfer valid |
| in_ready | output | 1 | Input transfer can be taken |
| in_data | input | 36 | Input transfer data |
| out_valid | output | 1 | Assembled long word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 36 | Assembled, reordered long word |
| out_mbox | output | 1 | Word came from a mailbox-code transfer |

## Verification
Random words are sent in every size with both part orders and all four reorder modes, with random data in the unused upper input bits. This separates slot placement errors from lane-reorder errors and from leakage of unused bits. Directed cases change `swap_sel` between the parts of one word, and change the size halfway through a word. Together they show whether the mode and size are captured at the right boundary. A size change followed by a transfer exactly one edge later shows whether the latch-then-apply delay is one stage too short. A stalled output with input still offered shows whether back-pressure holds the word and refuses new data.

// File: rtl/bm_pkg.sv
package bm_pkg;
  typedef enum logic [1:0] {
    SZ_LONG = 2'd0,
    SZ_WORD = 2'd1,
    SZ_BYTE = 2'd2,
    SZ_MBOX = 2'd3
  } bm_size_e;
endpackage

// File: rtl/bm_size_ctl.sv
module bm_size_ctl
  import bm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] size_sel,
  input  logic     order_sel,
  input  logic     boundary,
  output bm_size_e act_size,
  output logic     act_order
);
  bm_size_e req_size;
  logic     req_order;

  // stage 1: capture request every edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_size  <= SZ_LONG;
      req_order <= 1'b0;
    end else begin
      req_size  <= bm_size_e'(size_sel);
      req_order <= order_sel;
    end
  end

  // stage 2: apply only where no long word is partly collected
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_size  <= SZ_LONG;
      act_order <= 1'b0;
    end else if (boundary) begin
      act_size  <= req_size;
      act_order <= req_order;
    end
  end
endmodule

// File: rtl/bm_swap.sv
module bm_swap #(
  parameter int LANE_W = 9
) (
  input  logic [4*LANE_W-1:0] din,
  input  logic [1:0]          mode,
  output logic [4*LANE_W-1:0] dout
);
  localparam int LANES = 4;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int REV = LANES - 1 - i;
    localparam int HLF = i ^ 2;
    localparam int INH = i ^ 1;
    always_comb begin
      unique case (mode)
        2'd0:    dout[i*LANE_W +: LANE_W] = din[i*LANE_W   +: LANE_W];
        2'd1:    dout[i*LANE_W +: LANE_W] = din[REV*LANE_W +: LANE_W];
        2'd2:    dout[i*LANE_W +: LANE_W] = din[HLF*LANE_W +: LANE_W];
        default: dout[i*LANE_W +: LANE_W] = din[INH*LANE_W +: LANE_W];
      endcase
    end
  end
endmodule

// File: rtl/bm_packer.sv
module bm_packer
  import bm_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bm_size_e            act_size,
  input  logic                act_order,
  input  logic [1:0]          swap_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [4*LANE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [4*LANE_W-1:0] out_data,
  output logic                out_mbox,
  output logic                boundary,
  output logic [4*LANE_W-1:0] merged,
  output logic [1:0]          cur_swap,
  input  logic [4*LANE_W-1:0] swapped
);
  localparam int W  = 4 * LANE_W;
  localparam int HW = 2 * LANE_W;

  logic [1:0]   cnt, cnt_next, last_idx, slot, swap_q;
  logic [W-1:0] acc;
  logic         accept, last;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    unique case (act_size)
      SZ_WORD: last_idx = 2'd1;
      SZ_BYTE: last_idx = 2'd3;
      default: last_idx = 2'd0;
    endcase
  end

  assign slot     = act_order ? (last_idx - cnt) : cnt;
  assign last     = (cnt == last_idx);
  assign cur_swap = (cnt == 2'd0) ? swap_sel : swap_q;

  always_comb begin
    merged = acc;
    unique case (act_size)
      SZ_WORD: begin
        if (slot[0]) merged[W-1:HW] = in_data[HW-1:0];
        else         merged[HW-1:0] = in_data[HW-1:0];
      end
      SZ_BYTE: merged[slot*LANE_W +: LANE_W] = in_data[LANE_W-1:0];
      default: merged = in_data;
    endcase
  end

  always_comb begin
    cnt_next = cnt;
    if (accept) cnt_next = last ? 2'd0 : cnt + 2'd1;
  end
  assign boundary = (cnt_next == 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      acc    <= '0;
      swap_q <= '0;
    end else if (accept) begin
      cnt <= cnt_next;
      acc <= merged;
      if (cnt == 2'd0) swap_q <= swap_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_mbox  <= 1'b0;
    end else if (accept && last) begin
      out_valid <= 1'b1;
      out_data  <= swapped;
      out_mbox  <= (act_size == SZ_MBOX);
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_mbox  <= 1'b0;
    end
  end
endmodule

// File: rtl/bm_bus_matcher.sv
module bm_bus_matcher
  import bm_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          size_sel,
  input  logic                order_sel,
  input  logic [1:0]          swap_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [4*LANE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [4*LANE_W-1:0] out_data,
  output logic                out_mbox
);
  localparam int W = 4 * LANE_W;

  bm_size_e     act_size;
  logic         act_order, boundary;
  logic [W-1:0] merged, swapped;
  logic [1:0]   cur_swap;

  bm_size_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .order_sel(order_sel),
    .boundary(boundary), .act_size(act_size), .act_order(act_order)
  );

  bm_packer #(.LANE_W(LANE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .act_size(act_size), .act_order(act_order),
    .swap_sel(swap_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_mbox(out_mbox), .boundary(boundary),
    .merged(merged), .cur_swap(cur_swap), .swapped(swapped)
  );

  bm_swap #(.LANE_W(LANE_W)) u_swap (
    .din(merged), .mode(cur_swap), .dout(swapped)
  );
endmodule

// File: rtl/bm_bus_matcher_chk.sv
module bm_bus_matcher_chk
  import bm_pkg::*;
#(
  parameter int LANE_W = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          swap_sel,
  input logic                in_valid,
  input logic                in_ready,
  input logic [4*LANE_W-1:0] in_data,
  input logic                out_valid,
  input logic                out_ready,
  input logic [4*LANE_W-1:0] out_data,
  input logic                out_mbox,
  input bm_size_e            act_size,
  input logic                boundary
);
  // R11: a stalled word blocks the input and holds still
  p_stall_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_stall_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_mbox));
  // R7: mailbox flag only travels with a valid word
  p_mbox_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_mbox |-> out_valid);
  // R3: unswapped long-word transfer passes through in one edge
  p_long_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && act_size == SZ_LONG && swap_sel == 2'd0
    |=> out_valid && out_data == $past(in_data));
  // R10: the active size only moves at a long-word boundary
  p_size_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_size) |-> $past(boundary));
endmodule

bind bm_bus_matcher bm_bus_matcher_chk #(.LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .swap_sel(swap_sel), .in_valid(in_valid),
  .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_mbox(out_mbox),
  .act_size(act_size), .boundary(boundary)
);

// File: tb/bm_bus_matcher_test.sv
module bm_bus_matcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic        order_sel = 1'b0;
  logic [1:0]  swap_sel = 2'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_data;
  logic        out_mbox;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bm_bus_matcher uut (.*);

  task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] lane_swap(input logic [35:0] w, input logic [1:0] m);
    logic [8:0] a0, a1, a2, a3;
    {a3, a2, a1, a0} = w;
    case (m)
      2'd0: return {a3, a2, a1, a0};
      2'd1: return {a0, a1, a2, a3};
      2'd2: return {a1, a0, a3, a2};
      default: return {a2, a3, a0, a1};
    endcase
  endfunction

  function automatic logic [35:0] build(input logic [1:0] sz, input bit ord,
      input logic [35:0] p0, p1, p2, p3);
    logic [35:0] w;
    logic [35:0] p [4];
    p[0] = p0; p[1] = p1; p[2] = p2; p[3] = p3;
    w = '0;
    if (sz == 2'd1) begin
      for (int k = 0; k < 2; k++) w[(ord ? 1 - k : k) * 18 +: 18] = p[k][17:0];
    end else if (sz == 2'd2) begin
      for (int k = 0; k < 4; k++) w[(ord ? 3 - k : k) * 9 +: 9] = p[k][8:0];
    end else w = p0;
    return w;
  endfunction

  task automatic xfer(input logic [35:0] d, input logic [1:0] sw);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; swap_sel = sw;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic set_size(input logic [1:0] sz, input bit ord);
    @(negedge clk);
    size_sel = sz; order_sel = ord;
    repeat (2) @(posedge clk);
  endtask

  task automatic send_check(input logic [1:0] sz, input bit ord, input logic [1:0] sw,
      input logic [35:0] p0, p1, p2, p3, input string req);
    logic [35:0] e;
    int n;
    n = (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
    xfer(p0, sw);
    if (n > 1) xfer(p1, sw);
    if (n > 2) begin xfer(p2, sw); xfer(p3, sw); end
    e = lane_swap(build(sz, ord, p0, p1, p2, p3), sw);
    @(negedge clk);
    chk(out_valid === 1'b1, req, {35'd0, out_valid}, 36'd1);
    chk(out_data === e, req, out_data, e);
    chk(out_mbox === (sz == 2'd3), {req, " R7"}, {35'd0, out_mbox}, {35'd0, sz == 2'd3});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [35:0] p0, p1, p2, p3, e;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(out_valid === 1'b0, "R1", {35'd0, out_valid}, 36'd0);
    chk(out_mbox === 1'b0, "R1", {35'd0, out_mbox}, 36'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", {35'd0, in_ready}, 36'd1);
    send_check(2'd0, 1'b0, 2'd0, 36'h9_1234_5678, 0, 0, 0, "R1 R3");

    // R8 each swap mode on a long word
    for (int m = 0; m < 4; m++)
      send_check(2'd0, 1'b0, m[1:0], 36'h8_0C04_0201, 0, 0, 0, "R8");

    // R2: transfer on the second edge still uses the old size
    @(negedge clk);
    size_sel = 2'd1;
    @(posedge clk);
    xfer(36'h1_2345_6789, 2'd0);
    @(negedge clk);
    chk(out_valid === 1'b1 && out_data === 36'h1_2345_6789, "R2",
        out_data, 36'h1_2345_6789);
    xfer(36'hF_FFF0_1111, 2'd0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R2 R4", {35'd0, out_valid}, 36'd0);
    xfer(36'hA_AAA0_2222, 2'd0);
    e = {18'h02222, 18'h01111};
    @(negedge clk);
    chk(out_valid === 1'b1 && out_data === e, "R2 R4 R12", out_data, e);

    // R9: swap taken from the first part only
    xfer(36'h0_0000_0ABC, 2'd1);
    xfer(36'h0_0000_1DEF, 2'd2);
    e = lane_swap(build(2'd1, 1'b0, 36'h0ABC, 36'h1DEF, 0, 0), 2'd1);
    @(negedge clk);
    chk(out_data === e, "R9", out_data, e);

    // R10: size change mid-word deferred
    xfer(36'h0_0000_3333, 2'd0);
    set_size(2'd0, 1'b0);
    @(negedge clk);
    chk(out_valid === 1'b0, "R10", {35'd0, out_valid}, 36'd0);
    xfer(36'h0_0000_0444, 2'd0);
    e = build(2'd1, 1'b0, 36'h3333, 36'h0444, 0, 0);
    @(negedge clk);
    chk(out_valid === 1'b1 && out_data === e, "R10", out_data, e);
    send_check(2'd0, 1'b0, 2'd0, 36'h7_7777_7777, 0, 0, 0, "R10");

    // R7 mailbox code
    set_size(2'd3, 1'b0);
    send_check(2'd3, 1'b0, 2'd2, 36'hC_0FFE_E123, 0, 0, 0, "R7");

    // R11 back-pressure
    set_size(2'd0, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    xfer(36'h5_5555_AAAA, 2'd0);
    @(negedge clk);
    in_valid = 1'b1; in_data = 36'h0_DEAD_BEEF;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && in_ready === 1'b0, "R11", {35'd0, in_ready}, 36'd0);
      chk(out_data === 36'h5_5555_AAAA, "R11", out_data, 36'h5_5555_AAAA);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R11", {35'd0, out_valid}, 36'd0);

    // random mix: R3 R4 R5 R6 R8 R12
    for (int it = 0; it < 60; it++) begin
      logic [1:0] sz, sw;
      bit ord;
      sz = 2'($urandom_range(0, 3));
      ord = 1'($urandom);
      sw = 2'($urandom);
      p0 = {4'($urandom), 32'($urandom)};
      p1 = {4'($urandom), 32'($urandom)};
      p2 = {4'($urandom), 32'($urandom)};
      p3 = {4'($urandom), 32'($urandom)};
      set_size(sz, ord);
      send_check(sz, ord, sw, p0, p1, p2, p3,
                 ord ? "R6 R8 R12" : (sz == 2'd2 ? "R5 R8 R12" : "R3 R4 R8 R12"));
    end

    // R6 directed byte order
    set_size(2'd2, 1'b1);
    send_check(2'd2, 1'b1, 2'd0, 36'h1FF_00011, 36'h022, 36'h033, 36'h044, "R5 R6");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule